// File: doc/BRIEF.md
# SDRAM Bank State Tracker

This block follows the command stream on an SDRAM command bus and keeps a live record of what every bank is doing. On each clock edge where the command is valid, it decodes the chip-select, row-strobe, column-strobe and write-enable pins together with the bank address and the auto-precharge address bit. It then moves each bank through its life cycle: opening a row, row open, bursting with or without auto-precharge, precharging, and back to idle. The row-to-column delay, the precharge time, the write recovery time, the CAS latency and the burst length are all timed by per-bank counters.

The main job is to model what happens when a burst in one bank is cut short by a READ or WRITE to another bank. Once another bank takes the bus, a read with auto-precharge starts its precharge at once. A write with auto-precharge first waits out the write recovery time, counted from the interrupting command. A plain read that is cut short by another read keeps running for CAS latency cycles. A controller or a bus monitor uses the per-bank state codes and the one-cycle precharge-start pulses to schedule its next commands or to check them.

Top module: `sdr_bank_tracker`

## Requirements
- R1: A command counts only when cs_n is low. The pin pattern {ras_n,cas_n,we_n} selects the command: 011 is ACTIVE, 101 is READ, 100 is WRITE and 010 is PRECHARGE. Every other pattern, and any pattern with cs_n high, changes no bank.
- R2: A command is decoded only if cke is high at the current edge and was also high at the edge before. Otherwise it is ignored.
- R3: The state codes on bank_state[3*b+:3] are: 0 idle, 1 opening, 2 row open, 3 read, 4 write, 5 read with auto-precharge, 6 write with auto-precharge, 7 precharging. An ACTIVE to an idle bank puts it in state 1 for T_RCD cycles, and it then moves to state 2.
- R4: A PRECHARGE with ap low acts on the addressed bank. With ap high it acts on every bank. Each bank it acts on that is in state 2, 3 or 4 enters state 7 for T_RP cycles and then goes idle. pre_start[b] is high for exactly the first cycle of state 7.
- R5: A READ or WRITE to a bank in state 2, 3 or 4 starts a new burst. The bank enters state 3 or 4 when ap is low, or state 5 or 6 when ap is high. An uninterrupted plain burst lasts BURST_LEN cycles and then returns to state 2.
- R6: An uninterrupted burst with auto-precharge works as follows. A read enters state 7 right after its BURST_LEN cycles. A write stays in state 6 for a further T_WR cycles and then enters state 7.
- R7: A bank in state 5 enters state 7, with a pre_start pulse, in the cycle after a READ or WRITE to another bank is accepted.
- R8: A bank in state 6 that is still bursting stays in state 6 for T_WR cycles after a READ or WRITE to another bank is accepted, and then enters state 7.
- R9: An accepted READ or WRITE to another bank returns a bank in state 4 to state 2 in the next cycle. An accepted WRITE to another bank does the same for a bank in state 3.
- R10: An accepted READ to another bank ends a bank's state-3 burst after CAS_LAT more cycles, or at the burst's own end if that comes sooner.
- R11: A command that does not fit the addressed bank's state is ignored, and a READ or WRITE so ignored interrupts no other bank. Examples are an ACTIVE to an open bank, a READ to an idle bank, and a PRECHARGE to a bank in state 6.
- R12: After reset every bank is in state 0 and pre_start is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cke | input | 1 | Clock enable of the SDRAM command bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address of the command |
| ap | input | 1 | Auto-precharge / all-banks address bit |
| bank_state | output | 3*NUM_BANKS | State code per bank, bank b at bits 3*b+2:3*b |
| pre_start | output | NUM_BANKS | One-cycle pulse in the first precharge cycle of a bank |

## Verification
The hardest case to reach from the ports is a write with auto-precharge that is interrupted during its burst, while a second bank is being opened or read, so that the recovery count and the precharge overlap with other banks' timers. Directed sequences open all four banks and then chain the events: a READ with auto-precharge cut off by a READ, a plain read cut short, a WRITE with auto-precharge cut off by a WRITE, and a precharge to all banks. Each result is checked in the exact cycle the requirements name. A long random phase then biases the stimulus toward ACTIVE, READ and WRITE, so that bursts overlap often, and compares every bank to a cycle model on every cycle.

// File: rtl/sdr_trk_pkg.sv
package sdr_trk_pkg;

  typedef enum logic [2:0] {
    BK_IDLE    = 3'd0,
    BK_OPENING = 3'd1,
    BK_OPEN    = 3'd2,
    BK_RD      = 3'd3,
    BK_WR      = 3'd4,
    BK_RDA     = 3'd5,
    BK_WRA     = 3'd6,
    BK_PRE     = 3'd7
  } bank_st_e;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_RD  = 3'd2,
    OP_WR  = 3'd3,
    OP_PRE = 3'd4
  } op_e;

  localparam int ST_W = 3;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdr_trk_decode.sv
module sdr_trk_decode
  import sdr_trk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output op_e  op_o
);

  logic cke_q;

  // Previous-cycle clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cke_q <= 1'b0;
    else        cke_q <= cke;
  end

  always_comb begin
    op_o = OP_NOP;
    if (cke_q && cke && !cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b011:  op_o = OP_ACT;
        3'b101:  op_o = OP_RD;
        3'b100:  op_o = OP_WR;
        3'b010:  op_o = OP_PRE;
        default: op_o = OP_NOP;
      endcase
    end
  end

  // R2: a decoded command needs clock enable on this and the previous edge
  assert_cke_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_o != OP_NOP) |-> (cke && $past(cke)))
    else $error("command decoded outside the clock-enable window");

endmodule

// File: rtl/sdr_trk_bank.sv
module sdr_trk_bank
  import sdr_trk_pkg::*;
#(
  parameter int BANK_ID   = 0,
  parameter int BA_W      = 2,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_WR      = 2,
  parameter int CAS_LAT   = 3,
  parameter int BURST_LEN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  op_e             op,
  input  logic [BA_W-1:0] cmd_ba,
  input  logic            cmd_ap,
  input  logic            tgt_ok,
  output bank_st_e        st_o,
  output logic            pre_o
);

  localparam int CMAX = imax(imax(imax(T_RCD, T_RP), imax(T_WR, CAS_LAT)), BURST_LEN);
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] RCD_L = CW'(T_RCD - 1);
  localparam logic [CW-1:0] RP_L  = CW'(T_RP - 1);
  localparam logic [CW-1:0] WR_L  = CW'(T_WR - 1);
  localparam logic [CW-1:0] CL_L  = CW'(CAS_LAT - 1);
  localparam logic [CW-1:0] BL_L  = CW'(BURST_LEN - 1);

  bank_st_e        st_q, st_d;
  logic [CW-1:0]   bc_q, bc_d;     // burst cycles left
  logic [CW-1:0]   tc_q, tc_d;     // tRCD / tRP / tWR timer
  logic            rec_q, rec_d;   // write recovery running
  logic            ps_q, ps_d;

  logic     own, is_rw, rw_own, rw_other, pre_hit;
  bank_st_e st_start;
  logic [CW-1:0] bc_dec;

  assign own      = (cmd_ba == BA_W'(BANK_ID));
  assign is_rw    = (op == OP_RD) || (op == OP_WR);
  assign rw_own   = is_rw && own && tgt_ok;
  assign rw_other = is_rw && !own && tgt_ok;
  assign pre_hit  = (op == OP_PRE) && (own || cmd_ap);
  assign bc_dec   = bc_q - 1'b1;

  always_comb begin
    if (op == OP_RD) st_start = cmd_ap ? BK_RDA : BK_RD;
    else             st_start = cmd_ap ? BK_WRA : BK_WR;
  end

  always_comb begin
    st_d  = st_q;
    bc_d  = bc_q;
    tc_d  = tc_q;
    rec_d = rec_q;
    ps_d  = 1'b0;
    case (st_q)
      BK_IDLE: begin
        if (op == OP_ACT && own) begin
          st_d = BK_OPENING;
          tc_d = RCD_L;
        end
      end
      BK_OPENING: begin
        if (tc_q == '0) st_d = BK_OPEN;
        else            tc_d = tc_q - 1'b1;
      end
      BK_OPEN, BK_RD, BK_WR: begin
        if (rw_own) begin
          st_d = st_start;
          bc_d = BL_L;
        end else if (pre_hit) begin
          st_d = BK_PRE;
          tc_d = RP_L;
          ps_d = 1'b1;
        end else if (st_q != BK_OPEN) begin
          if (bc_q == '0) begin
            st_d = BK_OPEN;
          end else if (rw_other && (st_q == BK_WR || op == OP_WR)) begin
            st_d = BK_OPEN;
          end else if (rw_other) begin
            bc_d = (bc_dec < CL_L) ? bc_dec : CL_L;
          end else begin
            bc_d = bc_dec;
          end
        end
      end
      BK_RDA: begin
        if (bc_q == '0 || rw_other) begin
          st_d = BK_PRE;
          tc_d = RP_L;
          ps_d = 1'b1;
        end else begin
          bc_d = bc_dec;
        end
      end
      BK_WRA: begin
        if (rec_q) begin
          if (tc_q == '0) begin
            st_d  = BK_PRE;
            tc_d  = RP_L;
            ps_d  = 1'b1;
            rec_d = 1'b0;
          end else begin
            tc_d = tc_q - 1'b1;
          end
        end else if (bc_q == '0 || rw_other) begin
          rec_d = 1'b1;
          tc_d  = WR_L;
        end else begin
          bc_d = bc_dec;
        end
      end
      BK_PRE: begin
        if (tc_q == '0) st_d = BK_IDLE;
        else            tc_d = tc_q - 1'b1;
      end
      default: st_d = BK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= BK_IDLE;
      bc_q  <= '0;
      tc_q  <= '0;
      rec_q <= 1'b0;
      ps_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      bc_q  <= bc_d;
      tc_q  <= tc_d;
      rec_q <= rec_d;
      ps_q  <= ps_d;
    end
  end

  assign st_o  = st_q;
  assign pre_o = ps_q;

  // R4: the start pulse only appears while precharging, and never twice in a row
  assert_pulse_in_pre_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ps_q |-> (st_q == BK_PRE))
    else $error("precharge pulse outside precharge state");

  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ps_q |=> !ps_q)
    else $error("precharge pulse longer than one cycle");

  // R7: every entry into precharge is flagged by the pulse
  assert_pre_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BK_PRE && $past(st_q) != BK_PRE) |-> ps_q)
    else $error("precharge entered without pulse");

  // R4: idle is reached only through precharge
  assert_idle_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BK_IDLE && $past(st_q) != BK_IDLE) |-> ($past(st_q) == BK_PRE))
    else $error("idle entered without precharge");

  // R3: a row becomes open only after opening or at the end of a plain burst
  assert_open_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BK_OPEN && $past(st_q) != BK_OPEN) |->
      ($past(st_q) inside {BK_OPENING, BK_RD, BK_WR}))
    else $error("row open entered from a wrong state");

  // R8: write recovery only runs inside the auto-precharge write state
  assert_recovery_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rec_q |-> (st_q == BK_WRA))
    else $error("write recovery outside auto-precharge write");

endmodule

// File: rtl/sdr_bank_tracker.sv
module sdr_bank_tracker
  import sdr_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_WR      = 2,
  parameter int CAS_LAT   = 3,
  parameter int BURST_LEN = 8,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cke,
  input  logic                      cs_n,
  input  logic                      ras_n,
  input  logic                      cas_n,
  input  logic                      we_n,
  input  logic [BA_W-1:0]           ba,
  input  logic                      ap,
  output logic [ST_W*NUM_BANKS-1:0] bank_state,
  output logic [NUM_BANKS-1:0]      pre_start
);

  logic [1:0] rst_sync;
  logic       rst_i;
  op_e        op;
  bank_st_e   st_arr [NUM_BANKS];
  logic       tgt_ok;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  sdr_trk_decode u_dec (
    .clk   (clk),
    .rst_n (rst_i),
    .cke   (cke),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .op_o  (op)
  );

  // A burst command is accepted only by a bank with an open row
  assign tgt_ok = st_arr[ba] inside {BK_OPEN, BK_RD, BK_WR};

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    sdr_trk_bank #(
      .BANK_ID   (g),
      .BA_W      (BA_W),
      .T_RCD     (T_RCD),
      .T_RP      (T_RP),
      .T_WR      (T_WR),
      .CAS_LAT   (CAS_LAT),
      .BURST_LEN (BURST_LEN)
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_i),
      .op     (op),
      .cmd_ba (ba),
      .cmd_ap (ap),
      .tgt_ok (tgt_ok),
      .st_o   (st_arr[g]),
      .pre_o  (pre_start[g])
    );
    assign bank_state[g*ST_W +: ST_W] = st_arr[g];
  end

endmodule

// File: tb/sim_sdr_bank_tracker.sv
`timescale 1ns/1ps
module sim_sdr_bank_tracker;

  localparam int NB = 4, RCD = 3, RP = 3, TWR = 2, CL = 3, BL = 8;
  localparam int C_NOP = 0, C_ACT = 1, C_RD = 2, C_WR = 3, C_PRE = 4, C_REF = 5;

  logic clk, rst_n, cke, cs_n, ras_n, cas_n, we_n, ap;
  logic [1:0] ba;
  logic [3*NB-1:0] bank_state;
  logic [NB-1:0] pre_start;

  int n_chk = 0, n_fail = 0;
  int m_st [NB], m_bc [NB], m_tc [NB];
  bit m_rec [NB], m_ps [NB];
  bit m_ckeq, skip_model;

  sdr_bank_tracker #(.NUM_BANKS(NB), .T_RCD(RCD), .T_RP(RP), .T_WR(TWR),
                     .CAS_LAT(CL), .BURST_LEN(BL)) u0 (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .ap(ap),
    .bank_state(bank_state), .pre_start(pre_start));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int dst(input int b);
    return int'(bank_state[b*3 +: 3]);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int b = 0; b < NB; b++) begin
      m_st[b] = 0; m_bc[b] = 0; m_tc[b] = 0; m_rec[b] = 0; m_ps[b] = 0;
    end
    m_ckeq = 0;
  endtask

  task automatic model_step(input bit ck, input bit cs, input bit r, input bit c,
                            input bit w, input int bb, input bit a);
    int op;
    bit tok;
    int n_st [NB], n_bc [NB], n_tc [NB];
    bit n_rec [NB], n_ps [NB];
    op = C_NOP;
    if (m_ckeq && ck && !cs)
      case ({r, c, w})
        3'b011: op = C_ACT;
        3'b101: op = C_RD;
        3'b100: op = C_WR;
        3'b010: op = C_PRE;
        default: op = C_NOP;
      endcase
    m_ckeq = ck;
    tok = (m_st[bb] == 2) || (m_st[bb] == 3) || (m_st[bb] == 4);
    for (int b = 0; b < NB; b++) begin
      bit own, rwo, rwx, ph;
      own = (b == bb);
      rwo = (op == C_RD || op == C_WR) && own && tok;
      rwx = (op == C_RD || op == C_WR) && !own && tok;
      ph  = (op == C_PRE) && (own || a);
      n_st[b] = m_st[b]; n_bc[b] = m_bc[b]; n_tc[b] = m_tc[b];
      n_rec[b] = m_rec[b]; n_ps[b] = 0;
      case (m_st[b])
        0: if (op == C_ACT && own) begin n_st[b] = 1; n_tc[b] = RCD - 1; end
        1: if (m_tc[b] == 0) n_st[b] = 2; else n_tc[b] = m_tc[b] - 1;
        2, 3, 4: begin
          if (rwo) begin
            n_st[b] = (op == C_RD) ? (a ? 5 : 3) : (a ? 6 : 4);
            n_bc[b] = BL - 1;
          end else if (ph) begin
            n_st[b] = 7; n_tc[b] = RP - 1; n_ps[b] = 1;
          end else if (m_st[b] != 2) begin
            if (m_bc[b] == 0) n_st[b] = 2;
            else if (rwx && (m_st[b] == 4 || op == C_WR)) n_st[b] = 2;
            else if (rwx) n_bc[b] = (m_bc[b] - 1 < CL - 1) ? m_bc[b] - 1 : CL - 1;
            else n_bc[b] = m_bc[b] - 1;
          end
        end
        5: if (m_bc[b] == 0 || rwx) begin
             n_st[b] = 7; n_tc[b] = RP - 1; n_ps[b] = 1;
           end else n_bc[b] = m_bc[b] - 1;
        6: if (m_rec[b]) begin
             if (m_tc[b] == 0) begin
               n_st[b] = 7; n_tc[b] = RP - 1; n_ps[b] = 1; n_rec[b] = 0;
             end else n_tc[b] = m_tc[b] - 1;
           end else if (m_bc[b] == 0 || rwx) begin
             n_rec[b] = 1; n_tc[b] = TWR - 1;
           end else n_bc[b] = m_bc[b] - 1;
        default: if (m_tc[b] == 0) n_st[b] = 0; else n_tc[b] = m_tc[b] - 1;
      endcase
    end
    for (int b = 0; b < NB; b++) begin
      m_st[b] = n_st[b]; m_bc[b] = n_bc[b]; m_tc[b] = n_tc[b];
      m_rec[b] = n_rec[b]; m_ps[b] = n_ps[b];
    end
  endtask

  // One clock: drive at negedge, model after posedge, compare at next negedge
  task automatic cyc(input int op, input int b = 0, input bit a = 0,
                     input bit ck = 1, input bit cs = 0);
    bit [2:0] p;
    case (op)
      C_ACT:   p = 3'b011;
      C_RD:    p = 3'b101;
      C_WR:    p = 3'b100;
      C_PRE:   p = 3'b010;
      C_REF:   p = 3'b001;
      default: p = 3'b111;
    endcase
    {ras_n, cas_n, we_n} = p;
    cs_n = cs; cke = ck; ba = 2'(b); ap = a;
    @(posedge clk);
    if (!skip_model) model_step(ck, cs, p[2], p[1], p[0], b, a);
    @(negedge clk);
    for (int k = 0; k < NB; k++) begin
      chk("model R5 state", dst(k), m_st[k]);
      chk("model R4 pulse", int'(pre_start[k]), int'(m_ps[k]));
    end
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) cyc(C_NOP);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    model_reset();
    skip_model = 1;
    cyc(C_NOP); cyc(C_NOP);
    rst_n = 1'b1;
    cyc(C_NOP); cyc(C_NOP);
    skip_model = 0;
    cyc(C_NOP);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R12 actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 0; cke = 1; cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1; ba = 0; ap = 0;
    skip_model = 1;
    model_reset();
    @(negedge clk);
    do_reset();

    // R12 reset state
    for (int k = 0; k < NB; k++) chk("R12 idle", dst(k), 0);
    chk("R12 pulses", int'(pre_start), 0);

    // R2 clock-enable gating
    cyc(C_ACT, 0, 0, 0);      chk("R2 cke low", dst(0), 0);
    cyc(C_ACT, 0, 0, 1);      chk("R2 cke prev low", dst(0), 0);
    // R1 decode
    cyc(C_ACT, 0, 0, 1, 1);   chk("R1 cs high", dst(0), 0);
    cyc(C_REF, 0);            chk("R1 other pattern", dst(0), 0);
    cyc(C_ACT, 0);            chk("R1 active decoded", dst(0), 1);
    // R3 opening time
    nops(2);                  chk("R3 still opening", dst(0), 1);
    cyc(C_NOP);               chk("R3 row open", dst(0), 2);
    // R11 ignored commands
    cyc(C_ACT, 0);            chk("R11 act on open", dst(0), 2);
    cyc(C_RD, 1);             chk("R11 read idle bank", dst(1), 0);
    // R5 plain bursts
    cyc(C_RD, 0);             chk("R5 read", dst(0), 3);
    nops(BL - 1);             chk("R5 read last", dst(0), 3);
    cyc(C_NOP);               chk("R5 read end", dst(0), 2);
    cyc(C_WR, 0);             chk("R5 write", dst(0), 4);
    nops(BL);                 chk("R5 write end", dst(0), 2);
    // R4 single precharge
    cyc(C_PRE, 0);            chk("R4 pre state", dst(0), 7);
                              chk("R4 pulse", int'(pre_start), 1);
    cyc(C_NOP);               chk("R4 pulse once", int'(pre_start), 0);
    cyc(C_NOP);               chk("R4 still pre", dst(0), 7);
    cyc(C_NOP);               chk("R4 idle", dst(0), 0);
    // R6 read with auto-precharge
    cyc(C_ACT, 0); nops(RCD);
    cyc(C_RD, 0, 1);          chk("R6 read ap", dst(0), 5);
    nops(BL - 1);             chk("R6 read ap last", dst(0), 5);
    cyc(C_NOP);               chk("R6 read ap pre", dst(0), 7);
                              chk("R6 read ap pulse", int'(pre_start[0]), 1);
    nops(RP);                 chk("R6 read ap idle", dst(0), 0);
    // R6 write with auto-precharge, R11 precharge ignored in state 6
    cyc(C_ACT, 0); nops(RCD);
    cyc(C_WR, 0, 1);          chk("R6 write ap", dst(0), 6);
    cyc(C_PRE, 0);            chk("R11 pre on write ap", dst(0), 6);
    nops(BL + TWR - 2);       chk("R6 write ap recovery", dst(0), 6);
    cyc(C_NOP);               chk("R6 write ap pre", dst(0), 7);
                              chk("R6 write ap pulse", int'(pre_start[0]), 1);

    // Interrupt scenarios
    do_reset();
    for (int k = 0; k < NB; k++) cyc(C_ACT, k);
    nops(RCD);                chk("R3 all open", dst(3), 2);
    cyc(C_RD, 1, 1);          chk("R7 read ap", dst(1), 5);
    cyc(C_RD, 0);             chk("R7 cut pre", dst(1), 7);
                              chk("R7 cut pulse", int'(pre_start[1]), 1);
                              chk("R7 new read", dst(0), 3);
    cyc(C_RD, 2);             chk("R10 cut read", dst(0), 3);
    nops(CL - 1);             chk("R10 read tail", dst(0), 3);
    cyc(C_NOP);               chk("R10 read ends", dst(0), 2);
    cyc(C_WR, 3, 1);          chk("R9 read cut by write", dst(2), 2);
                              chk("R8 write ap", dst(3), 6);
    cyc(C_WR, 0);             chk("R8 cut wait", dst(3), 6);
    nops(TWR - 1);            chk("R8 recovery", dst(3), 6);
    cyc(C_NOP);               chk("R8 pre", dst(3), 7);
                              chk("R8 pulse", int'(pre_start[3]), 1);
    cyc(C_RD, 2);             chk("R9 write cut by read", dst(0), 2);
                              chk("R9 new read", dst(2), 3);
    cyc(C_PRE, 1, 1);         chk("R4 all pre b0", dst(0), 7);
                              chk("R4 all pre b2", dst(2), 7);
                              chk("R4 all pulses", int'(pre_start), 5);

    // Random phase
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      int r, op;
      r = int'($urandom % 16);
      if (r < 4)       op = C_NOP;
      else if (r < 7)  op = C_ACT;
      else if (r < 10) op = C_RD;
      else if (r < 13) op = C_WR;
      else if (r < 15) op = C_PRE;
      else             op = C_REF;
      cyc(op, int'($urandom % NB), bit'($urandom % 3 == 0),
          bit'($urandom % 20 != 0), bit'($urandom % 16 == 0));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule